// File: doc/BRIEF.md
# FM Discriminator Binary Demodulator

This block recovers a binary bit stream from a real-valued frequency-shift-keyed signal. The signal sits on an intermediate frequency of one quarter of the sample rate, which is 2.5 MHz at 10 Msample/s. Each accepted sample is multiplied by the sample accepted just before it. Because one sample spans a quarter of the IF period, this product turns frequency deviation into a slowly varying amplitude. A tone below the IF gives a positive mean product, and a tone above it gives a negative one.

The products go through a low-pass FIR with loadable coefficients. The FIR runs at the full sample rate. Its output is decimated by ten, so there is one decision per 1 Mbit/s bit period. The decimation phase is fixed while reset is held. Each kept value is sliced against zero to form a bit. The block takes 16-bit signed samples with a valid strobe and returns one bit with a valid strobe. It does no packet framing, no access-code search and no clock recovery.

Top module: `fmdisc_demod`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `bit_o` and `bit_vld_o` are 0. Reset sets all filter coefficients to 1. Reset also captures `dec_phase_i` as the decimation phase, which then stays fixed until the next reset.
- R2: The discriminator product for an accepted sample is `(cur*prev + 2^14) >>> 15`, where `prev` is the sample accepted before it. The result saturates to the range -32768..32767. The first sample after reset is only stored and yields no product.
- R3: The filtered value is the exact sum over k = 0..9 of `c[k]*p[n-k]`, where `p[n]` is the newest product. It uses a 36-bit accumulator that cannot overflow, even with full-scale coefficients and products.
- R4: A cycle with `coef_wr_i` high and `coef_idx_i` below 10 sets coefficient `c[coef_idx_i]` to `coef_i`. A write with `coef_idx_i` from 10 to 15 changes nothing.
- R5: No filtered value, and so no decision, exists before 11 samples have been accepted. The first filtered value (index 0) is formed from samples 1 to 11.
- R6: Filtered values are numbered from 0. Only those whose index modulo 10 equals the captured phase (0..9) become decisions.
- R7: The slicer outputs 1 for a filtered value strictly greater than zero, and 0 for a value of zero or below.
- R8: `bit_vld_o` is a one-cycle pulse. It appears two cycles after the clock edge that accepts the sample completing the decision. Idle cycles on `smp_vld_i` are skipped and change no result.
- R9: Take an FSK tone at IF ± 1 MHz, with a tone below the IF for bit 1. With the reset coefficients and phase 0, decision m equals transmitted bit m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 16 | Signed IF sample |
| smp_vld_i | input | 1 | Sample strobe |
| coef_wr_i | input | 1 | Coefficient write strobe |
| coef_idx_i | input | 4 | Coefficient index |
| coef_i | input | 16 | Signed coefficient value |
| dec_phase_i | input | 4 | Decimation phase, captured during reset |
| bit_o | output | 1 | Decided bit |
| bit_vld_o | output | 1 | Decision strobe |

## Verification
A stale or skipped delay sample corrupts every later product. A shifted tap or a narrow accumulator gives a wrong sign on some filtered value. Either fault reaches `bit_o` at the next decision, no more than ten accepted samples later. A wrong priming count or phase counter moves the first `bit_vld_o` by whole samples and changes the total number of decisions. This shows in the first decision and in the per-run decision count. The sweep over every phase is done with gap-free and gapped input, and extreme samples and coefficients exercise saturation and accumulator width.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  parameter int SMP_W  = 16;
  parameter int COEF_W = 16;
  parameter int PROD_W = SMP_W + COEF_W;

  // discriminator product rescaled to SMP_W bits, round half up, saturating
  function automatic logic signed [SMP_W-1:0] disc_scale(
    input logic signed [SMP_W-1:0] cur,
    input logic signed [SMP_W-1:0] prev);
    logic signed [2*SMP_W-1:0] full;
    logic signed [2*SMP_W:0]   rnd;
    full = cur * prev;
    rnd  = ($signed({full[2*SMP_W-1], full}) + (2*SMP_W+1)'(1 <<< (SMP_W-2))) >>> (SMP_W-1);
    if (rnd > (2*SMP_W+1)'((1 <<< (SMP_W-1)) - 1))
      return {1'b0, {(SMP_W-1){1'b1}}};
    else if (rnd < -(2*SMP_W+1)'(1 <<< (SMP_W-1)))
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return rnd[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/fmd_discrim.sv
module fmd_discrim
  import fmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    smp_vld_i,
  output logic signed [SMP_W-1:0] prod_o,
  output logic                    prod_vld_o
);
  logic signed [SMP_W-1:0] prev_q;
  logic                    have_prev_q;
  logic signed [SMP_W-1:0] prod_q;
  logic                    prod_vld_q;
  logic                    fire_w;

  assign fire_w = smp_vld_i && have_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      prod_q      <= '0;
      prod_vld_q  <= 1'b0;
    end else begin
      prod_vld_q <= fire_w;
      if (fire_w) prod_q <= disc_scale(smp_i, prev_q);
      if (smp_vld_i) begin
        prev_q      <= smp_i;
        have_prev_q <= 1'b1;
      end
    end
  end

  assign prod_o     = prod_q;
  assign prod_vld_o = prod_vld_q;

  AST_PROD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld_q |-> $past(smp_vld_i)); // R2
  AST_PROD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_q) |-> prod_vld_q); // R8
endmodule

// File: rtl/fmd_fir.sv
module fmd_fir
  import fmd_pkg::*;
#(
  parameter int NTAPS = 10,
  parameter int IDXW  = $clog2(NTAPS),
  parameter int ACCW  = PROD_W + $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [SMP_W-1:0]  prod_i,
  input  logic                     prod_vld_i,
  input  logic                     coef_wr_i,
  input  logic [IDXW-1:0]          coef_idx_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACCW-1:0]   acc_o,
  output logic                     acc_vld_o
);
  localparam int FW = $clog2(NTAPS);

  logic signed [COEF_W-1:0] coef_q [NTAPS];
  logic signed [SMP_W-1:0]  line_q [NTAPS-1];
  logic [FW-1:0]            fill_q;
  logic signed [PROD_W-1:0] term_w [NTAPS];
  logic signed [ACCW-1:0]   sum_w;
  logic signed [ACCW-1:0]   acc_q;
  logic                     acc_vld_q;
  logic                     filled_w;
  logic                     wr_hit_w;

  assign filled_w = (fill_q == FW'(NTAPS - 1));
  assign wr_hit_w = coef_wr_i && ({1'b0, coef_idx_i} < (IDXW+1)'(NTAPS));

  for (genvar k = 0; k < NTAPS; k++) begin : g_term
    if (k == 0) begin : g_new
      assign term_w[k] = coef_q[k] * prod_i;
    end else begin : g_old
      assign term_w[k] = coef_q[k] * line_q[k-1];
    end
  end

  always_comb begin
    sum_w = '0;
    for (int k = 0; k < NTAPS; k++) sum_w = sum_w + ACCW'(term_w[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) coef_q[k] <= COEF_W'(1);
      for (int k = 0; k < NTAPS-1; k++) line_q[k] <= '0;
      fill_q    <= '0;
      acc_q     <= '0;
      acc_vld_q <= 1'b0;
    end else begin
      if (wr_hit_w) coef_q[coef_idx_i] <= coef_i;
      acc_vld_q <= prod_vld_i && filled_w;
      if (prod_vld_i) begin
        line_q[0] <= prod_i;
        for (int k = 1; k < NTAPS-1; k++) line_q[k] <= line_q[k-1];
        if (!filled_w) fill_q <= fill_q + 1'b1;
        if (filled_w) acc_q <= sum_w;
      end
    end
  end

  assign acc_o     = acc_q;
  assign acc_vld_o = acc_vld_q;

  AST_FIR_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_q |-> $past(filled_w)); // R5
  AST_FIR_NEEDS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_q |-> $past(prod_vld_i)); // R5
endmodule

// File: rtl/fmd_decim_slice.sv
module fmd_decim_slice #(
  parameter int DEC  = 10,
  parameter int PW   = $clog2(DEC),
  parameter int ACCW = 36
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PW-1:0]          dec_phase_i,
  input  logic signed [ACCW-1:0] acc_i,
  input  logic                   acc_vld_i,
  output logic                   bit_o,
  output logic                   bit_vld_o
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] idx_q;
  logic          keep_w;
  logic          bit_q;
  logic          bit_vld_q;

  assign keep_w = acc_vld_i && (idx_q == phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= dec_phase_i;
      idx_q     <= '0;
      bit_q     <= 1'b0;
      bit_vld_q <= 1'b0;
    end else begin
      bit_vld_q <= keep_w;
      if (keep_w) bit_q <= (acc_i > 0);
      if (acc_vld_i) idx_q <= (idx_q == PW'(DEC - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = bit_vld_q;

  AST_BIT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_q |=> !bit_vld_q); // R8
  AST_BIT_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_q |-> (bit_q == ($past(acc_i) > 0))); // R7
  AST_BIT_NEEDS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_q |-> $past(acc_vld_i)); // R6
  AST_PHASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(phase_q)); // R1
endmodule

// File: rtl/fmdisc_demod.sv
module fmdisc_demod
  import fmd_pkg::*;
#(
  parameter int NTAPS = 10,
  parameter int DEC   = 10,
  localparam int IDXW = $clog2(NTAPS),
  localparam int PW   = $clog2(DEC),
  localparam int ACCW = PROD_W + $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [SMP_W-1:0]  smp_i,
  input  logic                     smp_vld_i,
  input  logic                     coef_wr_i,
  input  logic [IDXW-1:0]          coef_idx_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic [PW-1:0]            dec_phase_i,
  output logic                     bit_o,
  output logic                     bit_vld_o
);
  logic signed [SMP_W-1:0] prod_w;
  logic                    prod_vld_w;
  logic signed [ACCW-1:0]  acc_w;
  logic                    acc_vld_w;

  fmd_discrim i_discrim (
    .clk(clk), .rst_n(rst_n),
    .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .prod_o(prod_w), .prod_vld_o(prod_vld_w)
  );

  fmd_fir #(.NTAPS(NTAPS), .IDXW(IDXW), .ACCW(ACCW)) i_fir (
    .clk(clk), .rst_n(rst_n),
    .prod_i(prod_w), .prod_vld_i(prod_vld_w),
    .coef_wr_i(coef_wr_i), .coef_idx_i(coef_idx_i), .coef_i(coef_i),
    .acc_o(acc_w), .acc_vld_o(acc_vld_w)
  );

  fmd_decim_slice #(.DEC(DEC), .PW(PW), .ACCW(ACCW)) i_decim (
    .clk(clk), .rst_n(rst_n),
    .dec_phase_i(dec_phase_i),
    .acc_i(acc_w), .acc_vld_i(acc_vld_w),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );
endmodule

// File: tb/test_fmdisc_demod.sv
module test_fmdisc_demod;
  localparam int NT = 10;
  localparam int DV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] smp = '0;
  logic smp_vld = 1'b0;
  logic cw = 1'b0;
  logic [3:0] cidx = '0;
  logic signed [15:0] cdat = '0;
  logic [3:0] ph = '0;
  logic bit_o, bit_vld;

  fmdisc_demod i_fmdisc_demod (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(smp_vld),
    .coef_wr_i(cw), .coef_idx_i(cidx), .coef_i(cdat), .dec_phase_i(ph),
    .bit_o(bit_o), .bit_vld_o(bit_vld)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int stim[$];
  int txb[$];
  int expb[$];
  int got_b[$];
  int got_c[$];
  int drv_c[$];
  longint mc[NT];
  bit mon_en = 1'b0;

  always @(negedge clk)
    if (mon_en && bit_vld) begin
      got_b.push_back(int'(bit_o));
      got_c.push_back(cyc);
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint scale_m(longint a, longint b);
    longint r;
    r = (a * b + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // expected decisions from the requirement arithmetic
  task automatic build_expect(input int p);
    longint pr[$];
    expb.delete();
    for (int j = 0; j + 1 < stim.size(); j++) pr.push_back(scale_m(stim[j+1], stim[j]));
    for (int i = 0; i + NT - 1 < pr.size(); i++) begin
      longint f = 0;
      for (int k = 0; k < NT; k++) f += mc[k] * pr[i + NT - 1 - k];
      if (i % DV == p) expb.push_back(f > 0 ? 1 : 0);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0; ph = 4'(p); smp_vld = 1'b0; cw = 1'b0;
    for (int k = 0; k < NT; k++) mc[k] = 1;
    repeat (3) @(negedge clk);
    chk(bit_vld == 1'b0 && bit_o == 1'b0, "R1", "outputs in reset", {bit_vld, bit_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_vld == 1'b0 && bit_o == 1'b0, "R1", "outputs after reset", {bit_vld, bit_o}, 0);
  endtask

  task automatic wr(input int idx, input int v);
    @(negedge clk);
    cw = 1'b1; cidx = 4'(idx); cdat = 16'(v);
    @(negedge clk);
    cw = 1'b0;
    if (idx < NT) mc[idx] = v;
  endtask

  task automatic gen_fsk(input int nbits, input int seed);
    real phi = 0.0;
    int s = seed;
    stim.delete(); txb.delete();
    for (int b = 0; b < nbits; b++) begin
      int bv;
      real f;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      bv = (s >> 16) & 1;
      txb.push_back(bv);
      f = bv ? 0.15 : 0.35;
      for (int n = 0; n < DV; n++) begin
        stim.push_back($rtoi(20000.0 * $sin(phi)));
        phi = phi + 2.0 * 3.14159265358979 * f;
      end
    end
  endtask

  task automatic gen_noise(input int n, input int seed);
    logic [15:0] lf = 16'(seed) | 16'h1;
    stim.delete();
    for (int k = 0; k < n; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 7 == 3) stim.push_back(-32768);
      else if (k % 11 == 5) stim.push_back(32767);
      else stim.push_back(int'($signed(lf)));
    end
  endtask

  task automatic run(input int p, input bit gaps, input string req);
    int fd;
    build_expect(p);
    got_b.delete(); got_c.delete(); drv_c.delete();
    mon_en = 1'b1;
    for (int k = 0; k < stim.size(); k++) begin
      @(negedge clk);
      if (gaps && (k % 3 == 2)) begin
        smp_vld = 1'b0;
        @(negedge clk);
      end
      smp = 16'(stim[k]); smp_vld = 1'b1;
      drv_c.push_back(cyc);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (8) @(negedge clk);
    mon_en = 1'b0;
    chk(got_b.size() == expb.size(), req, "decision count", got_b.size(), expb.size());
    for (int m = 0; m < expb.size() && m < got_b.size(); m++)
      chk(got_b[m] == expb[m], req, $sformatf("decision %0d phase %0d", m, p), got_b[m], expb[m]);
    if (got_c.size() > 0 && drv_c.size() > NT + p) begin
      fd = got_c[0] - drv_c[NT + p];
      chk(fd == 3, "R5 R8", "first decision latency", fd, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 R5 R6 R7 R8: every phase, reset coefficients, FSK tone
    for (int p = 0; p < DV; p++) begin
      do_reset(p);
      gen_fsk(24, 17 + p);
      run(p, p[0], "R6");
      if (p == 0)
        for (int m = 0; m < got_b.size() && m < txb.size(); m++)
          chk(got_b[m] == txb[m], "R9", $sformatf("recovered bit %0d", m), got_b[m], txb[m]);
    end

    // R4 R3: loaded mixed-sign coefficients, noisy samples with extremes, gaps
    do_reset(3);
    wr(0, 3); wr(1, -2); wr(2, 5); wr(3, 7); wr(4, -1);
    wr(5, 4); wr(6, 0); wr(7, 2); wr(8, -6); wr(9, 1);
    gen_noise(160, 77);
    run(3, 1'b1, "R4");

    // R2 R3: saturated product with full-scale coefficients, both signs
    do_reset(5);
    for (int k = 0; k < NT; k++) wr(k, -32768);
    stim.delete();
    for (int k = 0; k < 45; k++) stim.push_back(-32768);
    run(5, 1'b0, "R3");
    do_reset(2);
    for (int k = 0; k < NT; k++) wr(k, 32767);
    run(2, 1'b0, "R2");

    // R7: zero coefficients give filtered value zero, sliced to 0
    do_reset(1);
    for (int k = 0; k < NT; k++) wr(k, 0);
    gen_fsk(12, 5);
    run(1, 1'b0, "R7");

    // R4: writes at indices 10 and 15 change nothing
    do_reset(0);
    wr(10, -5); wr(15, -300);
    gen_fsk(16, 9);
    run(0, 1'b0, "R4");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule